// File: doc/BRIEF.md
# Criticality-Ranked Cache Bank Scheduler

This block decides which request gets one bank of a last-level cache. In that cache, writes take far longer than reads. Four request classes arrive on separate valid/ready inputs: demand read, demand fill, prefetch fill and write-back. Each class has its own small queue. When the bank is idle, the scheduler starts the most critical waiting request.

A slow write-type operation that is already running can be abandoned when a more critical request turns up. This is allowed only while the elapsed part of the write is still below a per-class cut-off, which is set as a fraction of the write latency. An abandoned operation is not lost: it stays at the front of its queue and runs again from the start later on.

Back-pressure rules:
- A request is taken at a rising clock edge when its valid and ready are both high.
- Ready depends only on how full that class's queue is, never on valid.
- A sender may hold valid high for as long as it likes; nothing is taken while ready is low.

The outputs are the bank-busy level and three single-cycle pulses: start (grant), normal finish and abort. The pulses come with the class and tag of the operation concerned.

Top module: `crit_bank_sched`

## Requirements
- R1: Each class queue holds 4 entries, counting the operation currently occupying the bank. A class's ready is low exactly when its queue holds 4. A valid presented while ready is low is not taken. The other classes' readies are unaffected.
- R2: Classes are coded on op_cls as 0 = read, 1 = fill, 2 = prefetch fill, 3 = write-back. With cfg_share_top low, an idle bank is granted to the waiting class with the highest priority, in the order 0, 1, 2, 3.
- R3: With cfg_share_top high, read and fill form one level. The request of the two that was taken earlier is served first. When both were taken at the same edge, the read wins.
- R4: Requests of one class are served in the order they were taken.
- R5: bank_busy stays high for exactly cfg_rd_lat cycles for a read (intended 12 to 16) and exactly cfg_wr_lat cycles for the other classes (intended 20, 48 or 128). gnt_pulse is high in the first busy cycle. done_pulse is high in the cycle after the last busy cycle, and the bank is idle in that cycle.
- R6: Number the busy cycles from k = 1 at the grant. The running operation is aborted when both hold in cycle k: a request of strictly higher priority is waiting, and k is below the class limit. abort_pulse is then high and bank_busy low in the next cycle. An operation that reaches k equal to its latency finishes normally.
- R7: A class limit for latency L is set by a 2-bit code: 0 gives floor(L/4), 1 gives floor(L*77/128) (about 60%), 2 gives L (abortable on every cycle but the last), and 3 gives 0 (never abortable). Fill, prefetch fill and write-back each have their own code.
- R8: A read is never aborted. A request at the same priority level never aborts a running operation (for example a read arriving during a fill when cfg_share_top is high).
- R9: An aborted operation keeps its place at the head of its queue. When it is granted again, it occupies the bank for its full latency.
- R10: During reset all readies are high, bank_busy is low and all pulses are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_share_top | input | 1 | Read and fill share the top priority level |
| cfg_rd_lat | input | LAT_W | Read occupancy in cycles |
| cfg_wr_lat | input | LAT_W | Write-type occupancy in cycles |
| cfg_thr_fill | input | 2 | Abort-limit code for fills |
| cfg_thr_pf | input | 2 | Abort-limit code for prefetch fills |
| cfg_thr_wb | input | 2 | Abort-limit code for write-backs |
| rd_valid | input | 1 | Read request valid |
| rd_ready | output | 1 | Read queue can accept |
| rd_tag | input | TAG_W | Read request tag |
| fl_valid | input | 1 | Fill request valid |
| fl_ready | output | 1 | Fill queue can accept |
| fl_tag | input | TAG_W | Fill request tag |
| pf_valid | input | 1 | Prefetch-fill request valid |
| pf_ready | output | 1 | Prefetch-fill queue can accept |
| pf_tag | input | TAG_W | Prefetch-fill request tag |
| wb_valid | input | 1 | Write-back request valid |
| wb_ready | output | 1 | Write-back queue can accept |
| wb_tag | input | TAG_W | Write-back request tag |
| bank_busy | output | 1 | Bank occupied by an operation |
| gnt_pulse | output | 1 | Operation started this cycle |
| done_pulse | output | 1 | Operation finished normally |
| abort_pulse | output | 1 | Operation abandoned |
| op_cls | output | 2 | Class of the operation the pulses refer to |
| op_tag | output | TAG_W | Tag of the operation the pulses refer to |

## Verification
Four requests arriving on the same edge show whether the grant order follows the class ranking, not the arrival order or the port order. A burst on a single class shows whether order within a class is kept and whether back-pressure holds off a held valid. Higher-priority requests are injected at chosen busy cycles on either side of each limit code. A landing one cycle before the limit must abort; a landing on the limit must not. This also tells a correct comparison apart from an off-by-one. Shared-top runs mix staggered and same-edge read/fill arrivals, which separates age ordering and the tie rule. They also check that a fill is not aborted by a read of equal level.

// File: rtl/csched_pkg.sv
package csched_pkg;
  localparam int NCLS = 4;

  localparam logic [1:0] CLS_RD = 2'd0;
  localparam logic [1:0] CLS_FL = 2'd1;
  localparam logic [1:0] CLS_PF = 2'd2;
  localparam logic [1:0] CLS_WB = 2'd3;

  localparam logic [1:0] THR_QUARTER = 2'd0;
  localparam logic [1:0] THR_SIXTY   = 2'd1;
  localparam logic [1:0] THR_ALWAYS  = 2'd2;
  localparam logic [1:0] THR_NEVER   = 2'd3;

  // lower value = more critical
  function automatic logic [1:0] rank_of(input logic [1:0] cls, input logic share);
    case (cls)
      CLS_RD:  rank_of = 2'd0;
      CLS_FL:  rank_of = share ? 2'd0 : 2'd1;
      CLS_PF:  rank_of = 2'd2;
      default: rank_of = 2'd3;
    endcase
  endfunction
endpackage

// File: rtl/csched_fifo.sv
module csched_fifo #(
  parameter int DEPTH = 4,
  parameter int W     = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] head,
  output logic         empty,
  output logic         full
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [W-1:0] mem [DEPTH];
  logic [PW-1:0] wp, rp;
  logic [PW:0]   cnt;

  function automatic logic [PW-1:0] adv(input logic [PW-1:0] p);
    adv = (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (push) mem[wp] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (push) wp <= adv(wp);
      if (pop)  rp <= adv(rp);
      cnt <= cnt + (PW+1)'(push) - (PW+1)'(pop);
    end
  end

  assign head  = mem[rp];
  assign empty = (cnt == '0);
  assign full  = (cnt == (PW+1)'(DEPTH));

  p_no_overflow_r1: assert property (@(posedge clk) disable iff (!rst_n) push |-> !full);
  p_no_underflow_r4: assert property (@(posedge clk) disable iff (!rst_n) pop |-> !empty);
endmodule

// File: rtl/csched_limit.sv
module csched_limit #(
  parameter int LAT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LAT_W-1:0] lat,
  input  logic [1:0]       code,
  output logic [LAT_W-1:0] limit
);
  import csched_pkg::*;

  logic [LAT_W-1:0] lim_d;

  always_comb begin
    case (code)
      THR_QUARTER: lim_d = lat >> 2;
      THR_SIXTY:   lim_d = LAT_W'(({7'd0, lat} * 7'd77) >> 7);
      THR_ALWAYS:  lim_d = lat;
      default:     lim_d = '0;
    endcase
  end

  // product held in a register: settles one cycle after a configuration change
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) limit <= '0;
    else        limit <= lim_d;
  end

  p_limit_le_lat_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $stable(lat) && $stable(code) |-> limit <= lat);
endmodule

// File: rtl/csched_pick.sv
module csched_pick #(
  parameter int STAMP_W = 8
) (
  input  logic [csched_pkg::NCLS-1:0]              avail,
  input  logic [csched_pkg::NCLS-1:0][STAMP_W-1:0] stamp,
  input  logic                                     share,
  output logic                                     sel_valid,
  output logic [1:0]                               sel_cls,
  output logic [1:0]                               sel_rank
);
  import csched_pkg::*;

  function automatic logic older(input logic [STAMP_W-1:0] a, input logic [STAMP_W-1:0] b);
    logic [STAMP_W-1:0] d;
    d = a - b;
    older = d[STAMP_W-1];
  endfunction

  logic [STAMP_W-1:0] best_stamp;

  always_comb begin
    sel_valid  = 1'b0;
    sel_cls    = CLS_RD;
    sel_rank   = 2'd0;
    best_stamp = '0;
    for (int c = 0; c < NCLS; c++) begin
      logic [1:0] r;
      r = rank_of(2'(c), share);
      if (avail[c] && (!sel_valid || r < sel_rank ||
                       (r == sel_rank && older(stamp[c], best_stamp)))) begin
        sel_valid  = 1'b1;
        sel_cls    = 2'(c);
        sel_rank   = r;
        best_stamp = stamp[c];
      end
    end
  end

  always_comb begin
    a_sel_avail_r2: assert (!sel_valid || avail[sel_cls]);
    a_none_idle_r2: assert (sel_valid || avail == '0);
  end
endmodule

// File: rtl/crit_bank_sched.sv
module crit_bank_sched
  import csched_pkg::*;
#(
  parameter int QDEPTH  = 4,
  parameter int TAG_W   = 8,
  parameter int LAT_W   = 8,
  parameter int STAMP_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_share_top,
  input  logic [LAT_W-1:0] cfg_rd_lat,
  input  logic [LAT_W-1:0] cfg_wr_lat,
  input  logic [1:0]       cfg_thr_fill,
  input  logic [1:0]       cfg_thr_pf,
  input  logic [1:0]       cfg_thr_wb,
  input  logic             rd_valid,
  output logic             rd_ready,
  input  logic [TAG_W-1:0] rd_tag,
  input  logic             fl_valid,
  output logic             fl_ready,
  input  logic [TAG_W-1:0] fl_tag,
  input  logic             pf_valid,
  output logic             pf_ready,
  input  logic [TAG_W-1:0] pf_tag,
  input  logic             wb_valid,
  output logic             wb_ready,
  input  logic [TAG_W-1:0] wb_tag,
  output logic             bank_busy,
  output logic             gnt_pulse,
  output logic             done_pulse,
  output logic             abort_pulse,
  output logic [1:0]       op_cls,
  output logic [TAG_W-1:0] op_tag
);
  localparam int ENT_W = STAMP_W + TAG_W;

  logic [NCLS-1:0] in_valid, push, pop, full, empty, avail;
  logic [NCLS-1:0][TAG_W-1:0]   in_tag;
  logic [NCLS-1:0][ENT_W-1:0]   head;
  logic [NCLS-1:0][STAMP_W-1:0] head_stamp;
  logic [NCLS-1:0][LAT_W-1:0]   lim;
  logic [NCLS-1:1][1:0]         thr_code;

  logic               busy, gnt_q, done_q, abort_q;
  logic [1:0]         cur_cls;
  logic [TAG_W-1:0]   cur_tag;
  logic [LAT_W-1:0]   cur_lat, elapsed;
  logic [STAMP_W-1:0] stamp_ctr;

  logic       sel_valid, grant, finish, preempt;
  logic [1:0] sel_cls, sel_rank, cur_rank;

  assign in_valid = {wb_valid, pf_valid, fl_valid, rd_valid};
  assign in_tag   = {wb_tag, pf_tag, fl_tag, rd_tag};
  assign thr_code = {cfg_thr_wb, cfg_thr_pf, cfg_thr_fill};

  assign rd_ready = ~full[CLS_RD];
  assign fl_ready = ~full[CLS_FL];
  assign pf_ready = ~full[CLS_PF];
  assign wb_ready = ~full[CLS_WB];

  for (genvar c = 0; c < NCLS; c++) begin : g_cls
    assign push[c]       = in_valid[c] & ~full[c];
    // the running operation stays in its queue until it finishes
    assign pop[c]        = finish && (cur_cls == 2'(c));
    assign avail[c]      = ~empty[c] & ~(busy && (cur_cls == 2'(c)));
    assign head_stamp[c] = head[c][ENT_W-1:TAG_W];

    csched_fifo #(.DEPTH(QDEPTH), .W(ENT_W)) u_q (
      .clk(clk), .rst_n(rst_n),
      .push(push[c]), .din({stamp_ctr, in_tag[c]}),
      .pop(pop[c]), .head(head[c]),
      .empty(empty[c]), .full(full[c])
    );

    if (c == 0) begin : g_rd_lim
      assign lim[c] = '0;
    end else begin : g_wr_lim
      csched_limit #(.LAT_W(LAT_W)) u_lim (
        .clk(clk), .rst_n(rst_n),
        .lat(cfg_wr_lat), .code(thr_code[c]), .limit(lim[c])
      );
    end
  end

  csched_pick #(.STAMP_W(STAMP_W)) u_pick (
    .avail(avail), .stamp(head_stamp), .share(cfg_share_top),
    .sel_valid(sel_valid), .sel_cls(sel_cls), .sel_rank(sel_rank)
  );

  assign cur_rank = rank_of(cur_cls, cfg_share_top);
  assign finish   = busy && (elapsed == cur_lat);
  assign grant    = !busy && sel_valid;
  assign preempt  = busy && !finish && (cur_cls != CLS_RD) && sel_valid &&
                    (sel_rank < cur_rank) && (elapsed < lim[cur_cls]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      gnt_q     <= 1'b0;
      done_q    <= 1'b0;
      abort_q   <= 1'b0;
      cur_cls   <= CLS_RD;
      cur_tag   <= '0;
      cur_lat   <= '0;
      elapsed   <= '0;
      stamp_ctr <= '0;
    end else begin
      gnt_q   <= grant;
      done_q  <= finish;
      abort_q <= preempt;
      if (|push) stamp_ctr <= stamp_ctr + 1'b1;
      if (grant) begin
        busy    <= 1'b1;
        cur_cls <= sel_cls;
        cur_tag <= head[sel_cls][TAG_W-1:0];
        cur_lat <= (sel_cls == CLS_RD) ? cfg_rd_lat : cfg_wr_lat;
        elapsed <= LAT_W'(1);
      end else if (finish || preempt) begin
        busy <= 1'b0;
      end else if (busy) begin
        elapsed <= elapsed + 1'b1;
      end
    end
  end

  assign bank_busy   = busy;
  assign gnt_pulse   = gnt_q;
  assign done_pulse  = done_q;
  assign abort_pulse = abort_q;
  assign op_cls      = cur_cls;
  assign op_tag      = cur_tag;

  p_gnt_in_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
    gnt_pulse |-> bank_busy && !done_pulse && !abort_pulse);
  p_done_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done_pulse |-> !bank_busy);
  p_len_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    bank_busy |-> elapsed <= cur_lat);
  p_abort_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    abort_pulse |-> !bank_busy && !done_pulse);
  p_read_kept_r8: assert property (@(posedge clk) disable iff (!rst_n)
    abort_pulse |-> op_cls != CLS_RD);
  p_op_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
    bank_busy && !gnt_pulse |-> $stable(op_cls) && $stable(op_tag));
endmodule

// File: tb/crit_bank_sched_tb.sv
module crit_bank_sched_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_share_top = 1'b0;
  logic [7:0] cfg_rd_lat = 8'd12, cfg_wr_lat = 8'd20;
  logic [1:0] cfg_thr_fill = 2'd1, cfg_thr_pf = 2'd0, cfg_thr_wb = 2'd2;
  logic rd_valid = 0, fl_valid = 0, pf_valid = 0, wb_valid = 0;
  logic [7:0] rd_tag = 0, fl_tag = 0, pf_tag = 0, wb_tag = 0;
  logic rd_ready, fl_ready, pf_ready, wb_ready;
  logic bank_busy, gnt_pulse, done_pulse, abort_pulse;
  logic [1:0] op_cls;
  logic [7:0] op_tag;

  always #2 clk = ~clk;

  crit_bank_sched u_dut (.*);

  typedef struct { logic [1:0] cls; logic [7:0] tag; bit ab; int len; string req; } exp_t;
  exp_t sbq[$];
  int n_cmp = 0, n_bad = 0, cnt = 0;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic expect_op(input logic [1:0] c, input logic [7:0] t, input bit ab, input int len, input string req);
    exp_t e;
    e.cls = c; e.tag = t; e.ab = ab; e.len = len; e.req = req;
    sbq.push_back(e);
  endtask

  task automatic drv(input logic [1:0] c, input logic [7:0] t);
    case (c)
      2'd0: begin rd_valid = 1; rd_tag = t; end
      2'd1: begin fl_valid = 1; fl_tag = t; end
      2'd2: begin pf_valid = 1; pf_tag = t; end
      default: begin wb_valid = 1; wb_tag = t; end
    endcase
  endtask

  task automatic clr();
    rd_valid = 0; fl_valid = 0; pf_valid = 0; wb_valid = 0;
  endtask

  task automatic wait_gnt(input logic [7:0] t);
    do @(negedge clk); while (!(gnt_pulse && op_tag == t));
  endtask

  task automatic settle();
    while (sbq.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  // write-type op tag w, higher request h of class hc injected j cycles after grant
  task automatic inject(input logic [1:0] wc, input logic [7:0] w, input logic [1:0] hc,
                        input logic [7:0] h, input int j);
    @(negedge clk); drv(wc, w);
    @(negedge clk); clr();
    wait_gnt(w);
    repeat (j) @(negedge clk);
    drv(hc, h);
    @(negedge clk); clr();
    settle();
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n) begin
      if (gnt_pulse) begin
        if (sbq.size() == 0) chk(0, "R2", "unexpected grant tag", int'(op_tag), -1);
        else begin
          chk(op_cls == sbq[0].cls, sbq[0].req, "grant class", int'(op_cls), int'(sbq[0].cls));
          chk(op_tag == sbq[0].tag, sbq[0].req, "grant tag", int'(op_tag), int'(sbq[0].tag));
        end
        cnt = 1;
      end else if (bank_busy) cnt++;
      if (done_pulse || abort_pulse) begin
        if (sbq.size() == 0) chk(0, "R5", "unexpected end tag", int'(op_tag), -1);
        else begin
          exp_t e;
          e = sbq.pop_front();
          chk(abort_pulse == e.ab, e.req, "aborted", int'(abort_pulse), int'(e.ab));
          chk(cnt == e.len, e.req, "busy cycles", cnt, e.len);
        end
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10 reset state
    chk(rd_ready && fl_ready && pf_ready && wb_ready, "R10", "readies", 0, 1);
    chk(!bank_busy, "R10", "busy", int'(bank_busy), 0);
    chk(!gnt_pulse && !done_pulse && !abort_pulse, "R10", "pulses", 1, 0);
    rst_n = 1;
    repeat (3) @(negedge clk);

    // R2: all four classes on one edge
    expect_op(0, 1, 0, 12, "R2");
    expect_op(1, 2, 0, 20, "R2");
    expect_op(2, 3, 0, 20, "R2");
    expect_op(3, 4, 0, 20, "R5");
    @(negedge clk); drv(3, 4); drv(2, 3); drv(1, 2); drv(0, 1);
    @(negedge clk); clr();
    settle();

    // R4 order inside a class, R1 back-pressure
    for (int i = 0; i < 4; i++) expect_op(3, 8'(10 + i), 0, 20, "R4");
    for (int i = 0; i < 4; i++) begin
      @(negedge clk); drv(3, 8'(10 + i));
    end
    @(negedge clk); clr();
    chk(!wb_ready, "R1", "wb_ready when full", int'(wb_ready), 0);
    chk(rd_ready && fl_ready && pf_ready, "R1", "other readies", 0, 1);
    drv(3, 99);
    repeat (3) @(negedge clk);
    clr();
    settle();

    // R6 write-back (limit 20) aborted by reads
    expect_op(3, 40, 1, 5, "R6"); expect_op(0, 41, 0, 12, "R6"); expect_op(3, 40, 0, 20, "R9");
    inject(3, 40, 0, 41, 3);
    expect_op(3, 42, 1, 19, "R6"); expect_op(0, 43, 0, 12, "R6"); expect_op(3, 42, 0, 20, "R9");
    inject(3, 42, 0, 43, 17);
    expect_op(3, 44, 0, 20, "R6"); expect_op(0, 45, 0, 12, "R6");
    inject(3, 44, 0, 45, 18);

    // R7 limits: prefetch 25% -> 5, fill 60% -> 12
    expect_op(2, 50, 0, 20, "R7"); expect_op(1, 51, 0, 20, "R7");
    inject(2, 50, 1, 51, 3);
    expect_op(2, 52, 1, 4, "R7"); expect_op(1, 53, 0, 20, "R7"); expect_op(2, 52, 0, 20, "R9");
    inject(2, 52, 1, 53, 2);
    expect_op(1, 60, 1, 11, "R7"); expect_op(0, 61, 0, 12, "R7"); expect_op(1, 60, 0, 20, "R9");
    inject(1, 60, 0, 61, 9);
    expect_op(1, 62, 0, 20, "R7"); expect_op(0, 63, 0, 12, "R7");
    inject(1, 62, 0, 63, 10);
    cfg_thr_wb = 2'd3;
    repeat (3) @(negedge clk);
    expect_op(3, 70, 0, 20, "R7"); expect_op(0, 71, 0, 12, "R7");
    inject(3, 70, 0, 71, 0);

    // R3 shared top level, R8 equal level does not abort
    cfg_share_top = 1;
    repeat (3) @(negedge clk);
    expect_op(2, 30, 0, 20, "R3"); expect_op(1, 31, 0, 20, "R3");
    expect_op(0, 32, 0, 12, "R3"); expect_op(0, 34, 0, 12, "R3"); expect_op(1, 33, 0, 20, "R3");
    @(negedge clk); drv(2, 30);
    @(negedge clk); clr();
    wait_gnt(30);
    repeat (6) @(negedge clk);
    drv(1, 31);
    @(negedge clk); clr(); drv(0, 32);
    @(negedge clk); clr(); drv(1, 33); drv(0, 34);
    @(negedge clk); clr();
    settle();
    expect_op(1, 80, 0, 20, "R8"); expect_op(0, 81, 0, 12, "R8");
    inject(1, 80, 0, 81, 0);

    chk(sbq.size() == 0, "R5", "outstanding expected ops", sbq.size(), 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL R5 watchdog: actual %0d expected %0d", 100000, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule